// File: doc/BRIEF.md
# Recursive Modulo Transmit Precoder

This block sits in the transmit path of a serial memory link and pre-distorts the symbol stream so that the channel's trailing echoes cancel out at the receiver. For each accepted symbol it maps the symbol to a signed level. It subtracts a weighted sum of its own eight most recent drive codes. It then folds the difference back into a fixed 6-bit window. The result is a drive code for a segmented driver DAC. Because the weighted sum uses past outputs and not past inputs, the filter is recursive. The fold keeps the output inside the DAC range however the echoes add up.

Each symbol is either two-level or four-level, selected per symbol by a mode input. The eight feedback weights are static signed values written through a small register port. A receiver that wraps the channel output into the same 64-step window recovers the mapped level exactly. No decision error can feed back and propagate at the receiver.

Top module: `thp_precoder`

## Requirements
- R1: A synchronous active-low reset clears the drive code to 0, drv_vld to 0, all eight weights to 0 and the history of past drive codes to 0.
- R2: A pulse on tap_we stores tap_val (6-bit two's complement, value tap_val/32) as the weight at position tap_idx. The weight is used for every symbol accepted after that clock edge. Position i weights the drive code from i+1 symbols back.
- R3: In two-level mode (mode_pam4 = 0) only sym[0] counts: 0 maps to level -16 and 1 maps to level +16.
- R4: In four-level mode (mode_pam4 = 1), sym values 00, 01, 10 and 11 map to levels -24, -8, +8 and +24.
- R5: For each accepted symbol, the drive code is wrap(level - round(S / 32)). S is the sum of each weight code times the matching past drive code, taken at full precision. round adds 16 and then takes the floor. wrap folds into [-32, 31] modulo 64.
- R6: A cycle without sym_vld leaves the drive code and the history unchanged.
- R7: drv_vld is high in the cycle after each cycle with sym_vld high, and low otherwise. Each valid output belongs to exactly one accepted symbol, in order.
- R8: With all weights zero, the drive code equals the mapped level of the symbol.
- R9: The mode can change on any symbol and applies to that symbol only.
- R10: Passing the drive codes through a channel that adds round(S / 32) of the same weights, and then wrapping modulo 64, returns the mapped level of every symbol exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pam4 | input | 1 | 0 selects two-level, 1 selects four-level for the current symbol |
| sym_vld | input | 1 | A symbol is presented this cycle |
| sym | input | 2 | Symbol bits |
| tap_we | input | 1 | Weight write strobe |
| tap_idx | input | 3 | Weight position to write |
| tap_val | input | 6 | Signed weight value |
| drv_vld | output | 1 | drv_code carries a new result |
| drv_code | output | 6 | Signed drive code for the DAC |

## Verification
The hardest state to reach is one where the recursive sum repeatedly overflows the window. Only then does the modulo fold decide the output, and only then does a wrong fold or a wrong rounding carry differ from a correct one. The stimulus loads large weights of mixed sign, including the most negative code, and drives long runs of the outer four-level symbols with the mode flipped between symbols. Every output is compared against an independent model and also pushed through a matching channel and receive fold.

// File: rtl/thp_pkg.sv
// Shared types for the recursive modulo precoder.
package thp_pkg;
    // Symbol alphabet selector.
    typedef enum logic {
        MODE_NRZ  = 1'b0,
        MODE_PAM4 = 1'b1
    } thp_mode_e;
endpackage

// File: rtl/thp_sym_map.sv
// Maps a symbol to a signed level inside the output window.
// Assumes a window span of 2**OUT_W. Two-level symbols sit at +-span/4.
// Four-level symbols sit at +-span/8 and +-3*span/8, in binary order.
module thp_sym_map
    import thp_pkg::*;
#(
    parameter int OUT_W = 6
) (
    input  thp_mode_e                 mode,
    input  logic [1:0]                sym,
    output logic signed [OUT_W-1:0]   level
);
    localparam int SPAN  = 2 ** OUT_W;
    localparam int NRZ_A = SPAN / 4;
    localparam int P_IN  = SPAN / 8;
    localparam int P_OUT = 3 * SPAN / 8;

    // Pure lookup of the level for the current mode.
    always_comb begin
        if (mode == MODE_NRZ) begin
            level = sym[0] ? OUT_W'(NRZ_A) : OUT_W'(-NRZ_A);
        end else begin
            case (sym)
                2'b00:   level = OUT_W'(-P_OUT);
                2'b01:   level = OUT_W'(-P_IN);
                2'b10:   level = OUT_W'(P_IN);
                default: level = OUT_W'(P_OUT);
            endcase
        end
    end
endmodule

// File: rtl/thp_tap_regs.sv
// Static bank of signed feedback weights, written one at a time.
// Assumes the weights are changed only while the link is quiet.
// Cleared by the synchronous active-low reset.
module thp_tap_regs #(
    parameter int NTAP   = 8,
    parameter int COEF_W = 6,
    parameter int IDX_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [COEF_W-1:0]             val,
    output logic [NTAP-1:0][COEF_W-1:0]   coef,
    output logic                          all_zero
);
    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        // Capture a weight when its position is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                coef[g] <= '0;
            else if (we && idx == IDX_W'(g))
                coef[g] <= val;
        end
    end

    // Flag used for the pass-through check.
    assign all_zero = ~|coef;

    // R2
    tap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> coef[$past(idx)] == $past(val));
endmodule

// File: rtl/thp_fb_filter.sv
// Keeps the last NTAP drive codes and forms the rounded weighted sum.
// Only the low OUT_W bits of the rounded sum are returned, because the
// following subtraction is taken modulo 2**OUT_W anyway.
// Assumes FRAC >= 1 (weights are fixed point with FRAC fraction bits).
module thp_fb_filter #(
    parameter int NTAP   = 8,
    parameter int OUT_W  = 6,
    parameter int COEF_W = 6,
    parameter int FRAC   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [OUT_W-1:0]              new_code,
    input  logic [NTAP-1:0][COEF_W-1:0]   coef,
    output logic [OUT_W-1:0]              fb_mod
);
    localparam int PROD_W = OUT_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(NTAP) + 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);

    logic [NTAP-1:0][OUT_W-1:0]   hist;
    logic signed [PROD_W-1:0]     prod [NTAP];
    logic signed [ACC_W-1:0]      acc;
    logic signed [ACC_W-1:0]      acc_rnd;

    // History line: newest code enters at position 0 on each symbol.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[NTAP-2:0], new_code};
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_mul
        assign prod[g] = $signed(hist[g]) * $signed(coef[g]);
    end

    // Full-precision sum of all products.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++)
            acc = acc + ACC_W'(prod[i]);
    end

    // Round half up to the output LSB, keep the bits the modulo needs.
    assign acc_rnd = acc + HALF;
    assign fb_mod  = OUT_W'(acc_rnd >>> FRAC);

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[0] == $past(new_code) && hist[1] == $past(hist[0]));
    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));
endmodule

// File: rtl/thp_precoder.sv
// Recursive modulo precoder: drive = wrap(level - round(sum w_k*x[n-k])).
// The loop closes in one clock: the new code is registered at the output
// and enters the history line on the same edge.
// Assumes one symbol per clock at most, gated by sym_vld.
module thp_precoder
    import thp_pkg::*;
#(
    parameter int NTAP   = 8,
    parameter int OUT_W  = 6,
    parameter int COEF_W = 6,
    parameter int FRAC   = 5,
    localparam int IDX_W = $clog2(NTAP)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_pam4,
    input  logic                     sym_vld,
    input  logic [1:0]               sym,
    input  logic                     tap_we,
    input  logic [IDX_W-1:0]         tap_idx,
    input  logic [COEF_W-1:0]        tap_val,
    output logic                     drv_vld,
    output logic signed [OUT_W-1:0]  drv_code
);
    thp_mode_e                   mode;
    logic signed [OUT_W-1:0]     level;
    logic [NTAP-1:0][COEF_W-1:0] coef;
    logic                        taps_zero;
    logic [OUT_W-1:0]            fb_mod;
    logic [OUT_W-1:0]            code_next;

    assign mode = thp_mode_e'(mode_pam4);

    thp_sym_map #(.OUT_W(OUT_W)) u_map (
        .mode  (mode),
        .sym   (sym),
        .level (level)
    );

    thp_tap_regs #(.NTAP(NTAP), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tap_we),
        .idx      (tap_idx),
        .val      (tap_val),
        .coef     (coef),
        .all_zero (taps_zero)
    );

    thp_fb_filter #(.NTAP(NTAP), .OUT_W(OUT_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_fb (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sym_vld),
        .new_code (code_next),
        .coef     (coef),
        .fb_mod   (fb_mod)
    );

    // Modulo 2**OUT_W subtraction: truncation is the fold.
    assign code_next = level - fb_mod;

    // Output register and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_vld  <= 1'b0;
            drv_code <= '0;
        end else begin
            drv_vld <= sym_vld;
            if (sym_vld)
                drv_code <= code_next;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> drv_code == '0 && !drv_vld);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld |=> drv_vld);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> !drv_vld && $stable(drv_code));
    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld && taps_zero |=> drv_code == $past(level));
endmodule

// File: tb/thp_precoder_tb.sv
// Scoreboard bench: the driver pushes expected codes and levels, and the
// monitor pops them as results appear and also runs a channel model.
module thp_precoder_tb;
    localparam int NTAP = 8;
    localparam int FRAC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_pam4 = 1'b0;
    logic       sym_vld = 1'b0;
    logic [1:0] sym = '0;
    logic       tap_we = 1'b0;
    logic [2:0] tap_idx = '0;
    logic [5:0] tap_val = '0;
    logic       drv_vld;
    logic signed [5:0] drv_code;

    always #4 clk = ~clk;

    thp_precoder u_dut (
        .clk(clk), .rst_n(rst_n), .mode_pam4(mode_pam4), .sym_vld(sym_vld),
        .sym(sym), .tap_we(tap_we), .tap_idx(tap_idx), .tap_val(tap_val),
        .drv_vld(drv_vld), .drv_code(drv_code)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int lvl_q[$];
    int mh[NTAP];
    int ah[NTAP];
    int ctap[NTAP];
    int last_code = 0;
    bit done = 0;

    function automatic int wrap6(int v);
        int w = v & 63;
        return (w >= 32) ? w - 64 : w;
    endfunction

    function automatic int rnd(int acc);
        return (acc + (1 << (FRAC - 1))) >>> FRAC;
    endfunction

    function automatic int map_lvl(bit pam, int s);
        if (!pam) return (s & 1) ? 16 : -16;
        case (s & 3)
            0: return -24;
            1: return -8;
            2: return 8;
            default: return 24;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: present one symbol and push the model's expectation.
    task automatic send(bit pam, int s);
        int acc = 0;
        int lv;
        int e;
        @(negedge clk);
        mode_pam4 = pam; sym = 2'(s); sym_vld = 1'b1; tap_we = 1'b0;
        lv = map_lvl(pam, s);
        for (int k = 0; k < NTAP; k++) acc += ctap[k] * mh[k];
        e = wrap6(lv - rnd(acc));
        for (int k = NTAP - 1; k > 0; k--) mh[k] = mh[k-1];
        mh[0] = e;
        exp_q.push_back(e);
        lvl_q.push_back(lv);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sym_vld = 1'b0; tap_we = 1'b0;
        end
    endtask

    task automatic wr_tap(int i, int v);
        @(negedge clk);
        sym_vld = 1'b0; tap_we = 1'b1; tap_idx = 3'(i); tap_val = 6'(v);
        @(negedge clk);
        tap_we = 1'b0;
        ctap[i] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sym_vld = 1'b0; tap_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < NTAP; k++) begin mh[k] = 0; ah[k] = 0; ctap[k] = 0; end
        // R1: outputs cleared during reset
        check("R1 code", int'(drv_code), 0);
        check("R1 vld", int'(drv_vld), 0);
        rst_n = 1'b1;
    endtask

    // Monitor: compare results, run channel plus receive fold.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst_n) begin
                last_code = int'(drv_code);
            end else if (drv_vld) begin
                int e, lv, acc, r;
                bit tz;
                if (exp_q.size() == 0) begin
                    check("R7 unexpected valid", 1, 0);
                end else begin
                    e  = exp_q.pop_front();
                    lv = lvl_q.pop_front();
                    // R5 exact drive code
                    check("R5", int'(drv_code), e);
                    tz = 1;
                    for (int k = 0; k < NTAP; k++) if (ctap[k] != 0) tz = 0;
                    // R8 pass-through with zero weights
                    if (tz) check("R8", int'(drv_code), lv);
                    acc = 0;
                    for (int k = 0; k < NTAP; k++) acc += ctap[k] * ah[k];
                    r = wrap6(int'(drv_code) + rnd(acc));
                    for (int k = NTAP - 1; k > 0; k--) ah[k] = ah[k-1];
                    ah[0] = int'(drv_code);
                    // R10 receiver recovers the level
                    check("R10", r, lv);
                end
                last_code = int'(drv_code);
            end else begin
                // R6 idle cycle holds the code
                check("R6", int'(drv_code), last_code);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R3 R4 R8: zero weights, both alphabets
        for (int s = 0; s < 4; s++) send(1'b1, s);
        send(1'b0, 0); send(1'b0, 1); send(1'b0, 2); send(1'b0, 3);
        idle(3);
        // R2 R5: moderate weights, two-level stream
        wr_tap(0, 8); wr_tap(1, -4); wr_tap(2, 2); wr_tap(7, 1);
        for (int i = 0; i < 40; i++) send(1'b0, int'($urandom_range(0, 1)));
        idle(2);
        // R9: mode flips on each symbol
        for (int i = 0; i < 40; i++) send(1'(i), int'($urandom_range(0, 3)));
        idle(2);
        // R5 R10: heavy weights forcing repeated wraps
        wr_tap(0, -32); wr_tap(1, 31); wr_tap(2, -17); wr_tap(3, 25);
        wr_tap(4, -9);  wr_tap(5, 13); wr_tap(6, -32); wr_tap(7, 30);
        for (int i = 0; i < 60; i++) send(1'b1, (i % 3 == 0) ? 0 : 3);
        // R6: gaps in the middle of a stream
        for (int i = 0; i < 30; i++) begin
            send(1'(i % 2), int'($urandom_range(0, 3)));
            if (i % 4 == 0) idle(2);
        end
        idle(3);
        // R1: reset clears history and weights
        do_reset();
        wr_tap(0, 31); wr_tap(3, -20);
        for (int i = 0; i < 20; i++) send(1'b1, int'($urandom_range(0, 3)));
        idle(3);
        // R7: every pushed symbol produced a result
        check("R7 pending", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule